// File: doc/BRIEF.md
# Process-Tagged Translation Cache

This block keeps a small set of recent address translations, each labelled with the process that owns it. The key is a process identifier and a virtual page number; the result is a physical page number. A lookup port answers combinationally, in the same cycle: it gives hit or miss and, on a hit, the full physical address. That address is the stored physical page joined to the untouched 12-bit page offset. On a miss the surrounding logic walks the page tables elsewhere and installs the result through the fill port.

Every entry carries its owner's identifier. A switch between processes therefore leaves the contents in place. Two invalidation controls exist: one drops every entry, and one drops only the entries of one identifier when that identifier is about to be handed to a new process. Placement on fill follows a fixed order: an existing entry with the same key is rewritten first, then the lowest free slot is taken, and only when every slot is occupied does a rotating pointer choose the entry to replace.

Top module: `tlb_pid_cam`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports a miss.
- R2: A lookup hits only when a valid entry holds the same process ID and the same virtual page number. The page number is bits [31:12] of the 32-bit virtual address. On a hit the physical address is {stored page, vaddr[11:0]}, presented in the same cycle as the lookup.
- R3: On a miss the hit output is 0 and the physical address output is all zeros.
- R4: Identical page numbers under different process IDs are separate entries with separate results.
- R5: A fill whose key is not present goes to the lowest-indexed invalid entry.
- R6: When all 32 entries are valid, a fill with a new key replaces the entry at a rotating pointer. After reset the pointer starts at index 0. It moves up by one, wrapping after 31, only on such replacements.
- R7: A fill whose process ID and page number match a valid entry rewrites that entry in place. No other entry is displaced, and the pointer does not move.
- R8: A per-process flush invalidates, from the next cycle, every entry tagged with that process ID and leaves all other entries intact.
- R9: A full flush invalidates every entry from the next cycle.
- R10: When a fill and a flush (either kind) arrive in the same cycle, the fill's slot is chosen from the contents before the flush. The flush applies to the old contents, and the filled entry is valid afterwards.
- R11: A lookup in the same cycle as a fill sees the contents from before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_pid_i | input | 8 | Process ID of the lookup |
| lk_vaddr_i | input | 32 | Virtual address to translate |
| lk_hit_o | output | 1 | Translation found |
| lk_paddr_o | output | 32 | Translated physical address, zero on miss |
| fill_en_i | input | 1 | Install a translation this cycle |
| fill_pid_i | input | 8 | Process ID of the new translation |
| fill_vpn_i | input | 20 | Virtual page number of the new translation |
| fill_ppn_i | input | 20 | Physical page number of the new translation |
| flush_all_i | input | 1 | Invalidate every entry |
| flush_pid_en_i | input | 1 | Invalidate the entries of one process ID |
| flush_pid_i | input | 8 | Process ID to invalidate |

## Verification
A fill can land in the same cycle as a flush. The bench drives both in one cycle in two ways. In the first, fill and per-process flush name the same ID while old entries of that ID are still present. In the second, a fill is paired with a full flush. After the edge it looks up every key ever installed and compares each result with a reference table that picks the slot first, applies the flush, and then writes the slot. A lookup is also presented in the cycle of a fill, and it must miss until the edge has passed.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TLB_ENTRIES = 32;
  localparam int unsigned TLB_PID_W   = 8;
  localparam int unsigned TLB_VPN_W   = 20;
  localparam int unsigned TLB_PPN_W   = 20;
  localparam int unsigned TLB_OFF_W   = 12;

  typedef enum logic [1:0] {
    VSRC_MATCH = 2'd0,
    VSRC_FREE  = 2'd1,
    VSRC_RR    = 2'd2
  } vsrc_e;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int unsigned N     = 32,
  parameter int unsigned PID_W = 8,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PPN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PID_W-1:0] lk_pid_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic [N-1:0]     we_oh_i,
  input  logic [PID_W-1:0] wr_pid_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic             flush_all_i,
  input  logic             flush_pid_en_i,
  input  logic [PID_W-1:0] flush_pid_i,
  output logic [N-1:0]     lk_match_o,
  output logic [N-1:0]     wr_match_o,
  output logic [N-1:0]     valid_o,
  output logic [N*PPN_W-1:0] ppn_flat_o
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic             valid_q;
    logic [PID_W-1:0] pid_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;
    logic             kill;

    assign kill = flush_all_i || (flush_pid_en_i && (pid_q == flush_pid_i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        pid_q   <= '0;
        vpn_q   <= '0;
        ppn_q   <= '0;
      end else begin
        if (kill) valid_q <= 1'b0;
        // fill wins over a flush of the same cycle
        if (we_oh_i[i]) begin
          valid_q <= 1'b1;
          pid_q   <= wr_pid_i;
          vpn_q   <= wr_vpn_i;
          ppn_q   <= wr_ppn_i;
        end
      end
    end

    assign lk_match_o[i] = valid_q && (pid_q == lk_pid_i) && (vpn_q == lk_vpn_i);
    assign wr_match_o[i] = valid_q && (pid_q == wr_pid_i) && (vpn_q == wr_vpn_i);
    assign valid_o[i]    = valid_q;
    assign ppn_flat_o[i*PPN_W +: PPN_W] = ppn_q;

    AST_FILL_SETS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_oh_i[i] |=> valid_q && (ppn_q == $past(wr_ppn_i))); // R10
    AST_FLUSH_PID_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_pid_en_i && valid_q && (pid_q == flush_pid_i) && !we_oh_i[i]) |=> !valid_q); // R8
    AST_FLUSH_ALL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_all_i && !we_oh_i[i]) |=> !valid_q); // R9
  end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
  import tlb_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fill_en_i,
  input  logic [N-1:0] wr_match_i,
  input  logic [N-1:0] valid_i,
  output logic [N-1:0] victim_oh_o,
  output vsrc_e        src_o
);
  localparam int unsigned PTR_W = (N > 1) ? $clog2(N) : 1;

  logic [PTR_W-1:0] ptr_q;
  logic [N-1:0]     free_vec, free_oh, match_oh, rr_oh;

  assign free_vec = ~valid_i;

  always_comb begin
    free_oh  = '0;
    match_oh = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i])   free_oh  = N'(1) << i;
      if (wr_match_i[i]) match_oh = N'(1) << i;
    end
  end

  assign rr_oh = N'(1) << ptr_q;

  always_comb begin
    if (|wr_match_i) begin
      src_o       = VSRC_MATCH;
      victim_oh_o = match_oh;
    end else if (|free_vec) begin
      src_o       = VSRC_FREE;
      victim_oh_o = free_oh;
    end else begin
      src_o       = VSRC_RR;
      victim_oh_o = rr_oh;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (fill_en_i && (src_o == VSRC_RR))
      ptr_q <= (ptr_q == PTR_W'(N - 1)) ? '0 : ptr_q + 1'b1;
  end

  AST_VICTIM_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |-> $onehot(victim_oh_o)); // R5
  AST_FREE_NOT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en_i && (src_o == VSRC_FREE)) |-> ((victim_oh_o & valid_i) == '0)); // R5
  AST_PTR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en_i && (src_o == VSRC_MATCH)) |=> $stable(ptr_q)); // R7
endmodule

// File: rtl/tlb_ppn_mux.sv
module tlb_ppn_mux #(
  parameter int unsigned N     = 32,
  parameter int unsigned PPN_W = 20
) (
  input  logic [N-1:0]       match_i,
  input  logic [N*PPN_W-1:0] ppn_flat_i,
  output logic               hit_o,
  output logic [PPN_W-1:0]   ppn_o
);
  // and-or mux; match is one-hot by the no-duplicate rule
  always_comb begin
    ppn_o = '0;
    for (int i = 0; i < N; i++)
      ppn_o |= ppn_flat_i[i*PPN_W +: PPN_W] & {PPN_W{match_i[i]}};
  end
  assign hit_o = |match_i;
endmodule

// File: rtl/tlb_pid_cam.sv
module tlb_pid_cam
  import tlb_pkg::*;
#(
  parameter int unsigned N     = TLB_ENTRIES,
  parameter int unsigned PID_W = TLB_PID_W,
  parameter int unsigned VPN_W = TLB_VPN_W,
  parameter int unsigned PPN_W = TLB_PPN_W,
  parameter int unsigned OFF_W = TLB_OFF_W,
  localparam int unsigned VA_W = VPN_W + OFF_W,
  localparam int unsigned PA_W = PPN_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PID_W-1:0] lk_pid_i,
  input  logic [VA_W-1:0]  lk_vaddr_i,
  output logic             lk_hit_o,
  output logic [PA_W-1:0]  lk_paddr_o,
  input  logic             fill_en_i,
  input  logic [PID_W-1:0] fill_pid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             flush_all_i,
  input  logic             flush_pid_en_i,
  input  logic [PID_W-1:0] flush_pid_i
);
  logic [N-1:0]       lk_match, wr_match, valid, victim_oh, we_oh;
  logic [N*PPN_W-1:0] ppn_flat;
  logic [PPN_W-1:0]   hit_ppn;
  logic               hit;
  vsrc_e              vsrc;

  assign we_oh = victim_oh & {N{fill_en_i}};

  tlb_entry_array #(.N(N), .PID_W(PID_W), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_arr (
    .clk_i, .rst_ni,
    .lk_pid_i       (lk_pid_i),
    .lk_vpn_i       (lk_vaddr_i[VA_W-1:OFF_W]),
    .we_oh_i        (we_oh),
    .wr_pid_i       (fill_pid_i),
    .wr_vpn_i       (fill_vpn_i),
    .wr_ppn_i       (fill_ppn_i),
    .flush_all_i    (flush_all_i),
    .flush_pid_en_i (flush_pid_en_i),
    .flush_pid_i    (flush_pid_i),
    .lk_match_o     (lk_match),
    .wr_match_o     (wr_match),
    .valid_o        (valid),
    .ppn_flat_o     (ppn_flat)
  );

  tlb_victim_sel #(.N(N)) u_vic (
    .clk_i, .rst_ni,
    .fill_en_i   (fill_en_i),
    .wr_match_i  (wr_match),
    .valid_i     (valid),
    .victim_oh_o (victim_oh),
    .src_o       (vsrc)
  );

  tlb_ppn_mux #(.N(N), .PPN_W(PPN_W)) u_mux (
    .match_i    (lk_match),
    .ppn_flat_i (ppn_flat),
    .hit_o      (hit),
    .ppn_o      (hit_ppn)
  );

  assign lk_hit_o   = hit;
  assign lk_paddr_o = hit ? {hit_ppn, lk_vaddr_i[OFF_W-1:0]} : '0;

  AST_NO_DUP_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match) && $onehot0(wr_match)); // R7
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_paddr_o == '0)); // R3
  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (lk_paddr_o[OFF_W-1:0] == lk_vaddr_i[OFF_W-1:0])); // R2
  AST_FULL_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_all_i && !fill_en_i) |=> (valid == '0)); // R9
  AST_RR_ONLY_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en_i && (vsrc == VSRC_RR)) |-> (&valid)); // R6
endmodule

// File: tb/sim_tlb_pid_cam.sv
module sim_tlb_pid_cam;
  localparam int N = 32;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  lk_pid = '0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit;
  logic [31:0] lk_paddr;
  logic        fill_en = 1'b0;
  logic [7:0]  fill_pid = '0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic        flush_all = 1'b0, flush_pid_en = 1'b0;
  logic [7:0]  flush_pid = '0;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // reference table
  bit          m_v   [N];
  logic [7:0]  m_pid [N];
  logic [19:0] m_vpn [N];
  logic [19:0] m_ppn [N];
  int          m_ptr = 0;

  always #2 clk = ~clk;

  tlb_pid_cam u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_pid_i(lk_pid), .lk_vaddr_i(lk_vaddr),
    .lk_hit_o(lk_hit), .lk_paddr_o(lk_paddr),
    .fill_en_i(fill_en), .fill_pid_i(fill_pid), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
    .flush_all_i(flush_all), .flush_pid_en_i(flush_pid_en), .flush_pid_i(flush_pid)
  );

  task automatic model_op(bit fe, logic [7:0] p, logic [19:0] v, logic [19:0] pp,
                          bit fa, bit fpe, logic [7:0] fp);
    int idx = -1;
    if (fe) begin
      for (int i = 0; i < N; i++) if (idx < 0 && m_v[i] && m_pid[i] == p && m_vpn[i] == v) idx = i;
      for (int i = 0; i < N; i++) if (idx < 0 && !m_v[i]) idx = i;
      if (idx < 0) begin idx = m_ptr; m_ptr = (m_ptr + 1) % N; end
    end
    for (int i = 0; i < N; i++) if (fa || (fpe && m_pid[i] == fp)) m_v[i] = 1'b0;
    if (fe) begin m_v[idx] = 1'b1; m_pid[idx] = p; m_vpn[idx] = v; m_ppn[idx] = pp; end
  endtask

  task automatic op(bit fe, logic [7:0] p, logic [19:0] v, logic [19:0] pp,
                    bit fa, bit fpe, logic [7:0] fp);
    @(negedge clk);
    fill_en = fe; fill_pid = p; fill_vpn = v; fill_ppn = pp;
    flush_all = fa; flush_pid_en = fpe; flush_pid = fp;
    model_op(fe, p, v, pp, fa, fpe, fp);
    @(negedge clk);
    fill_en = 1'b0; flush_all = 1'b0; flush_pid_en = 1'b0;
  endtask

  task automatic look(logic [7:0] p, logic [19:0] v, logic [11:0] off, string tag);
    bit          eh = 1'b0;
    logic [31:0] ea = '0;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_pid[i] == p && m_vpn[i] == v) begin eh = 1'b1; ea = {m_ppn[i], off}; end
    lk_pid = p; lk_vaddr = {v, off};
    #1;
    tests++;
    if (lk_hit !== eh || lk_paddr !== ea) begin
      fails++;
      $display("FAIL %s pid=%0d vpn=%h: hit=%b paddr=%h expected hit=%b paddr=%h",
               tag, p, v, lk_hit, lk_paddr, eh, ea);
    end
  endtask

  task automatic look_all(string tag);
    for (int i = 0; i < N; i++) look(m_pid[i], m_vpn[i], 12'((i * 37) & 12'hfff), tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_pid[i] = '0; m_vpn[i] = '0; m_ppn[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 R3: empty after reset
    look(8'd0, 20'd0, 12'h000, "R1");
    look(8'd5, 20'hfffff, 12'hfff, "R3");
    rst_n = 1'b1;
    @(negedge clk);
    look(8'd0, 20'd8, 12'h123, "R1");

    // R4 R2: same page, two processes
    op(1, 8'd0, 20'd8, 20'd28, 0, 0, 8'd0);
    op(1, 8'd1, 20'd8, 20'd44, 0, 0, 8'd0);
    look(8'd0, 20'd8, 12'habc, "R4");
    look(8'd1, 20'd8, 12'h001, "R4");
    look(8'd2, 20'd8, 12'h001, "R3");
    look(8'd0, 20'd9, 12'h001, "R2");

    // R5: fill to capacity in index order
    for (int i = 0; i < N - 2; i++)
      op(1, 8'(i % 4), 20'(100 + i), 20'(12'h500 + i * 3), 0, 0, 8'd0);
    look_all("R5");

    // R7: rewrite in place, nothing displaced
    op(1, 8'd0, 20'd8, 20'd77, 0, 0, 8'd0);
    look_all("R7");
    look(8'd1, 20'd8, 12'h010, "R7");

    // R6: rotating replacement with wrap
    for (int i = 0; i < N + 8; i++) begin
      op(1, 8'(i % 3), 20'(1000 + i), 20'(12'h900 + i), 0, 0, 8'd0);
      look_all("R6");
      look(8'd0, 20'd8, 12'h004, "R6");
    end

    // R8: per-process flush, then R5 hole refill
    op(0, 8'd0, 20'd0, 20'd0, 0, 1, 8'd2);
    look_all("R8");
    for (int i = 0; i < 6; i++) begin
      op(1, 8'd7, 20'(3000 + i), 20'(12'hc00 + i), 0, 0, 8'd0);
      look_all("R5");
    end

    // R10: fill and per-process flush of the same ID together
    op(1, 8'd1, 20'd4000, 20'hab, 0, 1, 8'd1);
    look_all("R10");
    look(8'd1, 20'd4000, 12'h333, "R10");
    // R10: fill and full flush together
    op(1, 8'd9, 20'd4100, 20'hcd, 1, 0, 8'd0);
    look_all("R10");
    look(8'd9, 20'd4100, 12'h444, "R10");

    // R11: lookup in the fill cycle sees old contents
    @(negedge clk);
    fill_en = 1; fill_pid = 8'd3; fill_vpn = 20'd5000; fill_ppn = 20'h55;
    look(8'd3, 20'd5000, 12'h010, "R11");
    model_op(1, 8'd3, 20'd5000, 20'h55, 0, 0, 8'd0);
    @(negedge clk);
    fill_en = 0;
    look(8'd3, 20'd5000, 12'h010, "R11");

    // R9: full flush
    op(0, 8'd0, 20'd0, 20'd0, 1, 0, 8'd0);
    look_all("R9");
    look(8'd3, 20'd5000, 12'h010, "R9");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule